// File: doc/BRIEF.md
# Serial-to-Parallel Output Shift Controller

This block keeps an external chain of up to three 8-bit serial-in, parallel-out shift registers up to date with a 24-bit output image. It has three outputs to the chain: a serial data line, a shift clock made from the system clock by a programmable divider, and a store strobe that copies the shifted bits to the register outputs. Software holds a copy of the image and writes it through a small register port. A kick strobe forces the image to be sent again.

Some low-order bits can be taken over by hardware. A modem status interface can drive cascade bits 0 and 1. Two PHY status interfaces can each drive a 3-bit field: bits 2 to 4 for the first PHY and bits 5 to 7 for the second. Each bit has its own enable, and the bit that goes out is either the software value or the hardware value. A group mask sets how many 8-bit stages exist in the chain, and therefore how long a frame is. An edge-select input sets which shift-clock edge launches new data.

A frame starts by itself whenever the effective image of the enabled groups differs from the last image sent. The first software image is a build-time shadow value, which stands for the state the external registers are assumed to hold already.

Top module: `serout_top`

## Requirements
- R1: After reset the software image equals the SHADOW_INIT parameter and is treated as already sent. No frame starts until the image changes or a kick arrives, and a kick with no write sends exactly SHADOW_INIT.
- R2: A frame sends 8 bits for each group enabled in cfgGroupEn (bit g enables image bits 8g+7..8g). Groups are sent from the highest enabled group to the lowest, and bits within a group from the most significant down. Disabled groups are skipped.
- R3: When cfgModemEn[i] is 1, image bit i (i = 0..1) is taken from modemSt[i] instead of the software bit. A change on a modem input whose enable is 0 does not start a frame.
- R4: When cfgPhy1En[i] is 1, image bit 2+i comes from phy1St[i]. When cfgPhy2En[i] is 1, image bit 5+i comes from phy2St[i] (i = 0..2).
- R5: A frame starts on its own when the effective image differs from the last sent image in any enabled group. Changes confined to disabled groups start no frame.
- R6: A pulse on swKick starts a frame even when nothing changed. While cfgGroupEn is 0 no frame ever starts.
- R7: With cfgRiseEdge = 0 the shift clock idles low, data changes on its falling edge and the chain captures on its rising edge. With cfgRiseEdge = 1 the clock is inverted: it idles high and captures on the falling edge. serData is stable while the clock is at its capture level.
- R8: Each phase of the shift clock, high or low, lasts cfgDivider+1 system clock cycles.
- R9: After the last bit, serStore is high for exactly one system clock cycle, with the shift clock at its idle level.
- R10: busy is high for the whole frame, from the cycle after the start through the store cycle, which is 2*(cfgDivider+1)*bits+1 cycles. While busy is low the shift clock is idle and serStore is low.
- R11: A write during a frame does not change the bits of that frame. Once the frame ends, a new frame carrying the written image follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgGroupEn | input | GROUP_CNT | Enabled 8-bit groups of the chain |
| cfgModemEn | input | 2 | Per-bit modem override enables for bits 0..1 |
| cfgPhy1En | input | 3 | Per-bit PHY 1 override enables for bits 2..4 |
| cfgPhy2En | input | 3 | Per-bit PHY 2 override enables for bits 5..7 |
| cfgRiseEdge | input | 1 | 1: data launched on rising edge, clock idles high |
| cfgDivider | input | DIV_W | Shift clock half-period minus one, in system clocks |
| swWrEn | input | 1 | Write strobe for the software image |
| swWrData | input | GROUP_CNT*GROUP_W | New software image |
| swKick | input | 1 | Forces a frame |
| modemSt | input | 2 | Modem status bits |
| phy1St | input | 3 | PHY 1 status bits |
| phy2St | input | 3 | PHY 2 status bits |
| serData | output | 1 | Serial data to the chain |
| serClk | output | 1 | Shift clock |
| serStore | output | 1 | One-cycle store strobe |
| busy | output | 1 | A frame is in progress |

## Verification
The bench uses the default geometry of three 8-bit groups, so frames of 8, 16 and 24 bits and group skipping can all be reached. It overrides SHADOW_INIT with a pattern that differs from all zeros and all ones, so the bits of the reset image can be checked one by one. It sets the divider at run time, which makes the phase width and the total frame length measurable. With divider 3 a frame lasts long enough for a write to land in the middle of it.

// File: rtl/serout_pkg.sv
package serout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CAPT,
    ST_STORE
  } seroutState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;       // snapshot effective image, start at first bit
    logic advance;    // step to the next bit
    logic clkActive;  // shift clock at capture level
    logic storeOn;    // store pulse
  } seroutStrobe_s;

endpackage

// File: rtl/serout_fsm.sv
module serout_fsm
  import serout_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             startReq,
  input  logic             lastBit,
  output seroutStrobe_s    strobe,
  output logic             busy
);

  seroutState_e     state;
  logic [DIV_W-1:0] divCnt;
  logic             tickDone;

  assign tickDone = (divCnt == cfgDivider);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          divCnt <= '0;
          if (startReq) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tickDone) begin
            divCnt <= '0;
            state  <= ST_CAPT;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_CAPT: begin
          if (tickDone) begin
            divCnt <= '0;
            state  <= lastBit ? ST_STORE : ST_SETUP;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_STORE: begin
          divCnt <= '0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load      = (state == ST_IDLE) && startReq;
    strobe.advance   = (state == ST_CAPT) && tickDone && !lastBit;
    strobe.clkActive = (state == ST_CAPT);
    strobe.storeOn   = (state == ST_STORE);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/serout_path.sv
module serout_path
  import serout_pkg::*;
#(
  parameter int GROUP_CNT = 3,
  parameter int GROUP_W   = 8,
  parameter int MODEM_W   = 2,
  parameter int PHY_W     = 3,
  parameter logic [GROUP_CNT*GROUP_W-1:0] SHADOW_INIT = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [GROUP_CNT-1:0]           cfgGroupEn,
  input  logic [MODEM_W-1:0]             cfgModemEn,
  input  logic [PHY_W-1:0]               cfgPhy1En,
  input  logic [PHY_W-1:0]               cfgPhy2En,
  input  logic                           cfgRiseEdge,
  input  logic                           swWrEn,
  input  logic [GROUP_CNT*GROUP_W-1:0]   swWrData,
  input  logic                           swKick,
  input  logic [MODEM_W-1:0]             modemSt,
  input  logic [PHY_W-1:0]               phy1St,
  input  logic [PHY_W-1:0]               phy2St,
  input  seroutStrobe_s                  strobe,
  output logic                           startReq,
  output logic                           lastBit,
  output logic                           serData,
  output logic                           serClk,
  output logic                           serStore
);

  localparam int IMG_W   = GROUP_CNT * GROUP_W;
  localparam int IDX_W   = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int PHY1_LO = MODEM_W;
  localparam int PHY2_LO = MODEM_W + PHY_W;
  localparam int HW_TOP  = MODEM_W + 2 * PHY_W;

  logic [IMG_W-1:0]     swImg;
  logic [IMG_W-1:0]     sentImg;
  logic [IMG_W-1:0]     frameImg;
  logic [IMG_W-1:0]     effImg;
  logic [IMG_W-1:0]     grpMask;
  logic [GROUP_CNT-1:0] grpSnap;
  logic [IDX_W-1:0]     bitIdx;
  logic                 kickPend;
  logic [IDX_W:0]       firstPos;
  logic [IDX_W:0]       nextPos;

  // highest bit of the highest enabled group, with a valid flag on top
  function automatic logic [IDX_W:0] firstIdx(input logic [GROUP_CNT-1:0] en);
    logic [IDX_W:0] r;
    r = '0;
    for (int g = 0; g < GROUP_CNT; g++) begin
      if (en[g]) r = {1'b1, IDX_W'(g * GROUP_W + GROUP_W - 1)};
    end
    return r;
  endfunction

  // next bit to send after idx, skipping disabled groups
  function automatic logic [IDX_W:0] nextIdx(input logic [IDX_W-1:0] idx,
                                             input logic [GROUP_CNT-1:0] en);
    logic [IDX_W:0] r;
    int cur;
    cur = int'(idx);
    r   = '0;
    if ((cur % GROUP_W) != 0) begin
      r = {1'b1, idx - IDX_W'(1)};
    end else begin
      for (int g = 0; g < GROUP_CNT; g++) begin
        if (en[g] && (g < cur / GROUP_W)) r = {1'b1, IDX_W'(g * GROUP_W + GROUP_W - 1)};
      end
    end
    return r;
  endfunction

  // per-bit source selection
  for (genvar i = 0; i < IMG_W; i++) begin : g_bit
    if (i < MODEM_W) begin : g_modem
      assign effImg[i] = cfgModemEn[i] ? modemSt[i] : swImg[i];
    end else if (i < PHY2_LO) begin : g_phy1
      assign effImg[i] = cfgPhy1En[i-PHY1_LO] ? phy1St[i-PHY1_LO] : swImg[i];
    end else if (i < HW_TOP) begin : g_phy2
      assign effImg[i] = cfgPhy2En[i-PHY2_LO] ? phy2St[i-PHY2_LO] : swImg[i];
    end else begin : g_sw
      assign effImg[i] = swImg[i];
    end
  end

  for (genvar g = 0; g < GROUP_CNT; g++) begin : g_mask
    assign grpMask[g*GROUP_W +: GROUP_W] = {GROUP_W{cfgGroupEn[g]}};
  end

  assign firstPos = firstIdx(cfgGroupEn);
  assign nextPos  = nextIdx(bitIdx, grpSnap);
  assign lastBit  = !nextPos[IDX_W];
  assign startReq = (|cfgGroupEn) && (kickPend || (|((effImg ^ sentImg) & grpMask)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swImg    <= SHADOW_INIT;
      sentImg  <= SHADOW_INIT;
      frameImg <= SHADOW_INIT;
      grpSnap  <= '0;
      bitIdx   <= '0;
      kickPend <= 1'b0;
    end else begin
      if (swWrEn) swImg <= swWrData;

      if (swKick && (|cfgGroupEn)) kickPend <= 1'b1;
      else if (strobe.load)        kickPend <= 1'b0;

      if (strobe.load) begin
        frameImg <= effImg;
        sentImg  <= effImg;
        grpSnap  <= cfgGroupEn;
        bitIdx   <= firstPos[IDX_W-1:0];
      end else if (strobe.advance) begin
        bitIdx   <= nextPos[IDX_W-1:0];
      end
    end
  end

  assign serData  = frameImg[bitIdx];
  assign serClk   = strobe.clkActive ^ cfgRiseEdge;
  assign serStore = strobe.storeOn;

endmodule

// File: rtl/serout_top.sv
module serout_top
  import serout_pkg::*;
#(
  parameter int GROUP_CNT = 3,
  parameter int GROUP_W   = 8,
  parameter int DIV_W     = 8,
  parameter logic [GROUP_CNT*GROUP_W-1:0] SHADOW_INIT = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [GROUP_CNT-1:0]         cfgGroupEn,
  input  logic [1:0]                   cfgModemEn,
  input  logic [2:0]                   cfgPhy1En,
  input  logic [2:0]                   cfgPhy2En,
  input  logic                         cfgRiseEdge,
  input  logic [DIV_W-1:0]             cfgDivider,
  input  logic                         swWrEn,
  input  logic [GROUP_CNT*GROUP_W-1:0] swWrData,
  input  logic                         swKick,
  input  logic [1:0]                   modemSt,
  input  logic [2:0]                   phy1St,
  input  logic [2:0]                   phy2St,
  output logic                         serData,
  output logic                         serClk,
  output logic                         serStore,
  output logic                         busy
);

  seroutStrobe_s strobe;
  logic          startReq;
  logic          lastBit;

  serout_path #(
    .GROUP_CNT  (GROUP_CNT),
    .GROUP_W    (GROUP_W),
    .MODEM_W    (2),
    .PHY_W      (3),
    .SHADOW_INIT(SHADOW_INIT)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cfgGroupEn (cfgGroupEn),
    .cfgModemEn (cfgModemEn),
    .cfgPhy1En  (cfgPhy1En),
    .cfgPhy2En  (cfgPhy2En),
    .cfgRiseEdge(cfgRiseEdge),
    .swWrEn     (swWrEn),
    .swWrData   (swWrData),
    .swKick     (swKick),
    .modemSt    (modemSt),
    .phy1St     (phy1St),
    .phy2St     (phy2St),
    .strobe     (strobe),
    .startReq   (startReq),
    .lastBit    (lastBit),
    .serData    (serData),
    .serClk     (serClk),
    .serStore   (serStore)
  );

  serout_fsm #(
    .DIV_W(DIV_W)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .cfgDivider(cfgDivider),
    .startReq  (startReq),
    .lastBit   (lastBit),
    .strobe    (strobe),
    .busy      (busy)
  );

endmodule

// File: rtl/serout_chk.sv
module serout_chk #(
  parameter int GROUP_CNT = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [GROUP_CNT-1:0] cfgGroupEn,
  input logic                 cfgRiseEdge,
  input logic                 serData,
  input logic                 serClk,
  input logic                 serStore,
  input logic                 busy
);

  // R9
  store_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    serStore |=> !serStore);

  // R9
  store_idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    serStore |-> (busy && (serClk == cfgRiseEdge)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((serClk == cfgRiseEdge) && !serStore));

  // R7
  capture_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((serClk != cfgRiseEdge) && ($past(serClk) != $past(cfgRiseEdge))) |-> $stable(serData));

  // R6
  no_group_no_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgGroupEn == '0) && !busy) |=> !busy);

endmodule

bind serout_top serout_chk #(.GROUP_CNT(GROUP_CNT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgGroupEn (cfgGroupEn),
  .cfgRiseEdge(cfgRiseEdge),
  .serData    (serData),
  .serClk     (serClk),
  .serStore   (serStore),
  .busy       (busy)
);

// File: tb/serout_top_tb.sv
module serout_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] SHADOW = 24'h5A0F3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgGroupEn = 3'b111;
  logic [1:0]  cfgModemEn = '0;
  logic [2:0]  cfgPhy1En = '0;
  logic [2:0]  cfgPhy2En = '0;
  logic        cfgRiseEdge = 1'b0;
  logic [7:0]  cfgDivider = 8'd1;
  logic        swWrEn = 1'b0;
  logic [23:0] swWrData = '0;
  logic        swKick = 1'b0;
  logic [1:0]  modemSt = '0;
  logic [2:0]  phy1St = '0;
  logic [2:0]  phy2St = '0;
  logic        serData, serClk, serStore, busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [23:0] swShadow = SHADOW;

  // monitor state
  logic [23:0] capBits = '0;
  int          capLen = 0;
  logic [23:0] lastBits = '0, prevBits = '0;
  int          lastLen = 0, prevLen = 0;
  int          frameCnt = 0;
  bit          prevAct = 0;
  int          actW = 0, lastActW = 0;
  bit          prevBusy = 0;
  int          busyRun = 0, lastBusyLen = 0;
  bit          sawBusy = 0;

  serout_top #(.SHADOW_INIT(SHADOW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgGroupEn(cfgGroupEn), .cfgModemEn(cfgModemEn),
    .cfgPhy1En(cfgPhy1En), .cfgPhy2En(cfgPhy2En), .cfgRiseEdge(cfgRiseEdge),
    .cfgDivider(cfgDivider), .swWrEn(swWrEn), .swWrData(swWrData), .swKick(swKick),
    .modemSt(modemSt), .phy1St(phy1St), .phy2St(phy2St),
    .serData(serData), .serClk(serClk), .serStore(serStore), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // chain model: sampled away from the active edge
  always @(negedge clk) begin
    bit act;
    if (rstN) begin
      act = (serClk != cfgRiseEdge);
      if (act && !prevAct) begin
        capBits = {capBits[22:0], serData};
        capLen++;
        actW = 1;
      end else if (act) begin
        actW++;
      end
      if (!act && prevAct) lastActW = actW;
      prevAct = act;
      if (busy) begin busyRun++; sawBusy = 1; end
      if (!busy && prevBusy) begin lastBusyLen = busyRun; busyRun = 0; end
      prevBusy = busy;
      if (serStore) begin
        prevBits = lastBits; prevLen = lastLen;
        lastBits = capBits;  lastLen = capLen;
        capBits = '0; capLen = 0;
        frameCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expEff(input logic [23:0] sw);
    logic [23:0] r;
    r = sw;
    for (int i = 0; i < 2; i++) if (cfgModemEn[i]) r[i] = modemSt[i];
    for (int i = 0; i < 3; i++) if (cfgPhy1En[i]) r[2+i] = phy1St[i];
    for (int i = 0; i < 3; i++) if (cfgPhy2En[i]) r[5+i] = phy2St[i];
    return r;
  endfunction

  function automatic logic [23:0] expBits(input logic [23:0] img, input logic [2:0] en);
    logic [23:0] b;
    b = '0;
    for (int g = 2; g >= 0; g--)
      if (en[g]) for (int k = 7; k >= 0; k--) b = {b[22:0], img[g*8+k]};
    return b;
  endfunction

  function automatic int expLen(input logic [2:0] en);
    return 8 * (int'(en[0]) + int'(en[1]) + int'(en[2]));
  endfunction

  task automatic settle();
    int quiet;
    quiet = 0;
    repeat (3) @(negedge clk);
    while (quiet < 4) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic waitFrames(input int target);
    int t;
    t = 0;
    while (frameCnt < target && t < 8000) begin @(negedge clk); t++; end
  endtask

  task automatic doWrite(input logic [23:0] v);
    @(negedge clk); swWrEn = 1'b1; swWrData = v; swShadow = v;
    @(negedge clk); swWrEn = 1'b0;
  endtask

  task automatic doKick();
    @(negedge clk); swKick = 1'b1;
    @(negedge clk); swKick = 1'b0;
  endtask

  task automatic checkLast(input string req, input logic [23:0] img);
    chk(lastBits == expBits(img, cfgGroupEn), req, 32'(lastBits), 32'(expBits(img, cfgGroupEn)));
    chk(lastLen == expLen(cfgGroupEn), req, 32'(lastLen), 32'(expLen(cfgGroupEn)));
  endtask

  task automatic kickFrame(input string req);
    int base;
    base = frameCnt;
    doKick();
    waitFrames(base + 1);
    settle();
    chk(frameCnt == base + 1, req, 32'(frameCnt - base), 32'd1);
    checkLast(req, expEff(swShadow));
  endtask

  task automatic expectNoFrame(input string req, input int base);
    repeat (100) @(negedge clk);
    chk(frameCnt == base, req, 32'(frameCnt - base), 32'd0);
    chk(!sawBusy, req, 32'(sawBusy), 32'd0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && serStore == 1'b0 && serClk == 1'b0, "R10 reset idle",
        {29'd0, busy, serStore, serClk}, 32'd0);
    repeat (20) @(negedge clk);
    chk(frameCnt == 0, "R1 no frame after reset", 32'(frameCnt), 32'd0);
  endtask

  task automatic t_shadow();
    kickFrame("R1 shadow image by kick");
    chk(lastActW == 2, "R8 phase width div1", 32'(lastActW), 32'd2);
    chk(lastBusyLen == 2*2*24 + 1, "R10 busy length", 32'(lastBusyLen), 32'(2*2*24+1));
  endtask

  task automatic t_write();
    int base;
    base = frameCnt;
    doWrite(24'hA5C33C);
    waitFrames(base + 1); settle();
    chk(frameCnt == base + 1, "R5 write starts one frame", 32'(frameCnt - base), 32'd1);
    checkLast("R2 24-bit frame", 24'hA5C33C);
  endtask

  task automatic t_groups();
    int base;
    cfgGroupEn = 3'b101; settle();
    base = frameCnt;
    doWrite(24'h3C1E87);
    waitFrames(base + 1); settle();
    checkLast("R2 groups 2 and 0", 24'h3C1E87);
    cfgGroupEn = 3'b001; settle();
    base = frameCnt;
    doWrite(24'h3C1E55);
    waitFrames(base + 1); settle();
    checkLast("R2 group 0 only", 24'h3C1E55);
  endtask

  task automatic t_masked();
    int base;
    base = frameCnt; sawBusy = 0;
    doWrite(24'hFF0055);
    expectNoFrame("R5 disabled group change ignored", base);
  endtask

  task automatic t_zeroMask();
    int base;
    cfgGroupEn = 3'b000; settle();
    base = frameCnt; sawBusy = 0;
    doKick();
    expectNoFrame("R6 kick with no groups", base);
    cfgGroupEn = 3'b111; settle();
  endtask

  task automatic t_modem();
    int base;
    modemSt = 2'b11; cfgModemEn = 2'b10; settle();
    kickFrame("R3 modem override bit 1");
    base = frameCnt; sawBusy = 0;
    @(negedge clk); modemSt[0] = ~modemSt[0];
    expectNoFrame("R3 disabled modem bit ignored", base);
    base = frameCnt;
    @(negedge clk); modemSt[1] = 1'b0;
    waitFrames(base + 1); settle();
    chk(frameCnt == base + 1, "R5 hardware change starts frame", 32'(frameCnt - base), 32'd1);
    checkLast("R3 modem bit follows input", expEff(swShadow));
    cfgModemEn = 2'b00; settle();
  endtask

  task automatic t_phy();
    phy1St = 3'b011; phy2St = 3'b110;
    cfgPhy1En = 3'b101; cfgPhy2En = 3'b011;
    doWrite(24'h000000); settle();
    kickFrame("R4 phy overrides");
    cfgPhy1En = '0; cfgPhy2En = '0; settle();
  endtask

  task automatic t_rise();
    cfgRiseEdge = 1'b1; settle();
    chk(serClk == 1'b1, "R7 idle high in rise mode", 32'(serClk), 32'd1);
    doWrite(24'h6B29D4); settle();
    kickFrame("R7 rise mode frame");
    cfgRiseEdge = 1'b0; settle();
    chk(serClk == 1'b0, "R7 idle low in fall mode", 32'(serClk), 32'd0);
  endtask

  task automatic t_divider();
    cfgDivider = 8'd3; settle();
    kickFrame("R8 frame at divider 3");
    chk(lastActW == 4, "R8 phase width div3", 32'(lastActW), 32'd4);
    chk(lastBusyLen == 2*4*24 + 1, "R10 busy length div3", 32'(lastBusyLen), 32'(2*4*24+1));
  endtask

  task automatic t_midWrite();
    int base;
    logic [23:0] firstV;
    firstV = 24'h13579B;
    base = frameCnt;
    doWrite(firstV);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    doWrite(24'hECA864);
    waitFrames(base + 2); settle();
    chk(frameCnt == base + 2, "R11 two frames", 32'(frameCnt - base), 32'd2);
    chk(prevBits == firstV, "R11 frame undisturbed", 32'(prevBits), 32'(firstV));
    chk(lastBits == 24'hECA864, "R11 follow-up frame", 32'(lastBits), 32'hECA864);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_shadow();
    t_write();
    t_groups();
    t_masked();
    t_zeroMask();
    t_modem();
    t_phy();
    t_rise();
    t_divider();
    t_midWrite();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule